// File: doc/BRIEF.md
# Status and Acknowledge Frame Builder

This block builds the outgoing frames that a control board sends to its host. It produces them as a byte stream for an external MAC device, which adds the preamble and the checksum itself. A one-cycle start strobe selects one of two frame kinds and copies every parallel input into internal registers. The frame is then emitted one byte per accepted handshake, with a valid/ready pair and a flag on the final byte.

Every frame begins with a header. The header holds the stored partner MAC as the destination, then the local MAC as the source, then a two-byte length. The payload follows.

- A status frame carries the board's location byte, a type code, a 10-bit temperature reading and eight 12-bit converter readings.
- An acknowledge frame carries the location byte, its own type code and all 32 stored 14-bit output-channel values.

Each multi-byte field is split into a high byte and a low byte. The high byte holds the top bits of the value, padded with zeros above them. Short payloads are extended with zero bytes up to 47 bytes. The length field still reports only the meaningful payload bytes.

Top module: `stat_ack_frame_tx`

## Requirements
- R1: While rst_ni is low, and whenever no frame is in progress, tx_valid_o and tx_last_o are 0 and tx_data_o is 8'h00.
- R2: A frame starts with the 6 bytes of dst_mac_i, most significant byte (bits 47:40) first, followed by the 6 bytes of src_mac_i in the same order.
- R3: Frame bytes 12 and 13 are the payload length, high byte first. The value is 20 (16'h0014) for a status frame and 66 (16'h0042) for an acknowledge frame, with padding not counted.
- R4: When kind_i is 0 at start, the frame is a status frame. Its payload begins with loc_i, then the type byte 8'h53, then {6'b0, temp_i[9:8]}, then temp_i[7:0].
- R5: In a status frame, the temperature is followed by converter channels 0 to 7 in ascending order. Channel k is adc_i[12k+11:12k] and is sent as {4'b0, bits 11:8}, then bits 7:0.
- R6: When kind_i is 1 at start, the frame is an acknowledge frame. Its payload is loc_i, then 8'h44, then channels 0 to 31 in ascending order. Channel k is dac_i[14k+13:14k] and is sent as {2'b0, bits 13:8}, then bits 7:0.
- R7: A payload shorter than 47 bytes is followed by zero bytes up to 47 bytes. A status frame is therefore 61 bytes long, and an acknowledge frame (66-byte payload, no padding) is 80 bytes long.
- R8: tx_last_o is 1 exactly while the final byte of the frame is presented. After that byte's handshake, tx_valid_o is 0 in the next cycle.
- R9: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o, tx_data_o and tx_last_o keep their values into the next cycle.
- R10: A frame begins only after a start strobe seen while idle. A strobe during a frame, including during the final byte's handshake cycle, is ignored, and so are input changes made after the start. The frame in progress continues unchanged, and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; captures all data inputs when idle |
| kind_i | input | 1 | Frame kind: 0 status, 1 acknowledge |
| dst_mac_i | input | 48 | Partner (destination) MAC |
| src_mac_i | input | 48 | Local (source) MAC |
| loc_i | input | 8 | Board location byte |
| temp_i | input | 10 | Temperature reading |
| adc_i | input | 96 | Eight 12-bit converter readings, channel 0 in the low bits |
| dac_i | input | 448 | Thirty-two 14-bit output-channel values, channel 0 in the low bits |
| tx_ready_i | input | 1 | Sink accepts the current byte |
| tx_data_o | output | 8 | Current frame byte |
| tx_valid_o | output | 1 | A frame byte is presented |
| tx_last_o | output | 1 | Current byte is the final byte of the frame |

## Verification
The delicate overlap is a start strobe landing in the same cycle as the final byte's handshake. In that cycle the sequencer is both finishing a frame and being asked to begin another. The bench raises start_i just before the edge that accepts the last byte. It then checks that tx_valid_o is low in the following cycle, so the strobe was not taken as a new frame. A second case raises start_i in the middle of every table-driven frame while scrambling all data inputs and flipping kind_i. That frame must still match the bytes predicted from the values captured at its own start.

// File: rtl/stat_frame_pkg.sv
package stat_frame_pkg;
  typedef enum logic {
    KIND_STATUS = 1'b0,
    KIND_ACK    = 1'b1
  } frame_kind_e;

  localparam logic [7:0] TYPE_STATUS = 8'h53;
  localparam logic [7:0] TYPE_ACK    = 8'h44;
  localparam int         HDR_BYTES   = 14;
endpackage

// File: rtl/sf_capture.sv
module sf_capture
  import stat_frame_pkg::*;
#(
  parameter int TEMP_W = 10,
  parameter int N_ADC  = 8,
  parameter int ADC_W  = 12,
  parameter int N_DAC  = 32,
  parameter int DAC_W  = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  frame_kind_e            kind_i,
  input  logic [47:0]            dst_i,
  input  logic [47:0]            src_i,
  input  logic [7:0]             loc_i,
  input  logic [TEMP_W-1:0]      temp_i,
  input  logic [N_ADC*ADC_W-1:0] adc_i,
  input  logic [N_DAC*DAC_W-1:0] dac_i,
  output frame_kind_e            kind_o,
  output logic [47:0]            dst_o,
  output logic [47:0]            src_o,
  output logic [7:0]             loc_o,
  output logic [TEMP_W-1:0]      temp_o,
  output logic [N_ADC*ADC_W-1:0] adc_o,
  output logic [N_DAC*DAC_W-1:0] dac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= KIND_STATUS;
      dst_o  <= '0;
      src_o  <= '0;
      loc_o  <= '0;
      temp_o <= '0;
      adc_o  <= '0;
      dac_o  <= '0;
    end else if (load_i) begin
      kind_o <= kind_i;
      dst_o  <= dst_i;
      src_o  <= src_i;
      loc_o  <= loc_i;
      temp_o <= temp_i;
      adc_o  <= adc_i;
      dac_o  <= dac_i;
    end
  end
endmodule

// File: rtl/sf_seq.sv
module sf_seq #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             at_last_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o    = start_i && !busy_q;  // strobes while busy are dropped
  assign busy_o    = busy_q;
  assign idx_o     = idx_q;
  assign at_last_o = busy_q && (idx_q == last_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && ready_i) begin
      if (idx_q == last_idx_i) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/sf_byte_sel.sv
module sf_byte_sel
  import stat_frame_pkg::*;
#(
  parameter int TEMP_W   = 10,
  parameter int N_ADC    = 8,
  parameter int ADC_W    = 12,
  parameter int N_DAC    = 32,
  parameter int DAC_W    = 14,
  parameter int IDX_W    = 7,
  parameter int STAT_LEN = 4 + 2 * N_ADC,
  parameter int ACK_LEN  = 2 + 2 * N_DAC
) (
  input  logic [IDX_W-1:0]       idx_i,
  input  frame_kind_e            kind_i,
  input  logic [47:0]            dst_i,
  input  logic [47:0]            src_i,
  input  logic [7:0]             loc_i,
  input  logic [TEMP_W-1:0]      temp_i,
  input  logic [N_ADC*ADC_W-1:0] adc_i,
  input  logic [N_DAC*DAC_W-1:0] dac_i,
  output logic [7:0]             byte_o
);
  logic [15:0] len_w;
  logic [15:0] word;
  int          i;
  int          p;
  int          ch;

  assign len_w = (kind_i == KIND_ACK) ? 16'(ACK_LEN) : 16'(STAT_LEN);

  // Fields are widened to 16 bits, so the zero padding of each high byte follows the field width
  always_comb begin
    byte_o = 8'h00;
    word   = 16'h0000;
    ch     = 0;
    i      = int'(idx_i);
    p      = i - HDR_BYTES;
    if (i < 6) begin
      byte_o = dst_i[8*(5-i) +: 8];
    end else if (i < 12) begin
      byte_o = src_i[8*(11-i) +: 8];
    end else if (i == 12) begin
      byte_o = len_w[15:8];
    end else if (i == 13) begin
      byte_o = len_w[7:0];
    end else if (p == 0) begin
      byte_o = loc_i;
    end else if (p == 1) begin
      byte_o = (kind_i == KIND_ACK) ? TYPE_ACK : TYPE_STATUS;
    end else if (kind_i == KIND_STATUS) begin
      if (p < 4) begin
        word   = 16'(temp_i);
        byte_o = (p == 2) ? word[15:8] : word[7:0];
      end else if (p < STAT_LEN) begin
        ch     = (p - 4) / 2;
        word   = 16'(adc_i[ch*ADC_W +: ADC_W]);
        byte_o = (p % 2 == 0) ? word[15:8] : word[7:0];
      end
    end else if (p < ACK_LEN) begin
      ch     = (p - 2) / 2;
      word   = 16'(dac_i[ch*DAC_W +: DAC_W]);
      byte_o = (p % 2 == 0) ? word[15:8] : word[7:0];
    end
  end
endmodule

// File: rtl/stat_ack_frame_tx.sv
module stat_ack_frame_tx
  import stat_frame_pkg::*;
#(
  parameter int TEMP_W      = 10,
  parameter int N_ADC       = 8,
  parameter int ADC_W       = 12,
  parameter int N_DAC       = 32,
  parameter int DAC_W       = 14,
  parameter int MIN_PAYLOAD = 47
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   kind_i,
  input  logic [47:0]            dst_mac_i,
  input  logic [47:0]            src_mac_i,
  input  logic [7:0]             loc_i,
  input  logic [TEMP_W-1:0]      temp_i,
  input  logic [N_ADC*ADC_W-1:0] adc_i,
  input  logic [N_DAC*DAC_W-1:0] dac_i,
  input  logic                   tx_ready_i,
  output logic [7:0]             tx_data_o,
  output logic                   tx_valid_o,
  output logic                   tx_last_o
);
  localparam int STAT_LEN   = 4 + 2 * N_ADC;
  localparam int ACK_LEN    = 2 + 2 * N_DAC;
  localparam int STAT_FRAME = HDR_BYTES + ((STAT_LEN > MIN_PAYLOAD) ? STAT_LEN : MIN_PAYLOAD);
  localparam int ACK_FRAME  = HDR_BYTES + ((ACK_LEN > MIN_PAYLOAD) ? ACK_LEN : MIN_PAYLOAD);
  localparam int MAX_FRAME  = (STAT_FRAME > ACK_FRAME) ? STAT_FRAME : ACK_FRAME;
  localparam int IDX_W      = $clog2(MAX_FRAME);

  frame_kind_e            kind_q;
  logic [47:0]            dst_q, src_q;
  logic [7:0]             loc_q;
  logic [TEMP_W-1:0]      temp_q;
  logic [N_ADC*ADC_W-1:0] adc_q;
  logic [N_DAC*DAC_W-1:0] dac_q;
  logic                   load, busy, at_last;
  logic [IDX_W-1:0]       idx, last_idx;
  logic [7:0]             sel_byte;

  assign last_idx = (kind_q == KIND_ACK) ? IDX_W'(ACK_FRAME - 1) : IDX_W'(STAT_FRAME - 1);

  sf_capture #(
    .TEMP_W(TEMP_W), .N_ADC(N_ADC), .ADC_W(ADC_W), .N_DAC(N_DAC), .DAC_W(DAC_W)
  ) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .kind_i (frame_kind_e'(kind_i)),
    .dst_i  (dst_mac_i),
    .src_i  (src_mac_i),
    .loc_i  (loc_i),
    .temp_i (temp_i),
    .adc_i  (adc_i),
    .dac_i  (dac_i),
    .kind_o (kind_q),
    .dst_o  (dst_q),
    .src_o  (src_q),
    .loc_o  (loc_q),
    .temp_o (temp_q),
    .adc_o  (adc_q),
    .dac_o  (dac_q)
  );

  sf_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ready_i    (tx_ready_i),
    .last_idx_i (last_idx),
    .load_o     (load),
    .busy_o     (busy),
    .at_last_o  (at_last),
    .idx_o      (idx)
  );

  sf_byte_sel #(
    .TEMP_W(TEMP_W), .N_ADC(N_ADC), .ADC_W(ADC_W), .N_DAC(N_DAC), .DAC_W(DAC_W),
    .IDX_W(IDX_W), .STAT_LEN(STAT_LEN), .ACK_LEN(ACK_LEN)
  ) u_sel (
    .idx_i  (idx),
    .kind_i (kind_q),
    .dst_i  (dst_q),
    .src_i  (src_q),
    .loc_i  (loc_q),
    .temp_i (temp_q),
    .adc_i  (adc_q),
    .dac_i  (dac_q),
    .byte_o (sel_byte)
  );

  assign tx_valid_o = busy;
  assign tx_last_o  = at_last;
  assign tx_data_o  = busy ? sel_byte : 8'h00;
endmodule

// File: rtl/stat_ack_frame_tx_chk.sv
module stat_ack_frame_tx_chk #(
  parameter int STAT_FRAME = 61,
  parameter int ACK_FRAME  = 80
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_last_o
);
  logic        hs;
  logic [15:0] cnt_q;

  assign hs = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (hs && tx_last_o) cnt_q <= '0;
    else if (hs)              cnt_q <= cnt_q + 16'd1;
  end

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> (tx_data_o == 8'h00 && !tx_last_o));

  assert_frame_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && tx_last_o) |-> (cnt_q == 16'(STAT_FRAME - 1) || cnt_q == 16'(ACK_FRAME - 1)));

  assert_last_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && tx_last_o) |=> !tx_valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

  assert_begin_on_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(start_i));

  assert_no_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !(hs && tx_last_o)) |=> tx_valid_o);
endmodule

bind stat_ack_frame_tx stat_ack_frame_tx_chk #(
  .STAT_FRAME(STAT_FRAME),
  .ACK_FRAME (ACK_FRAME)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_last_o  (tx_last_o)
);

// File: tb/stat_ack_frame_tx_tb_top.sv
module stat_ack_frame_tx_tb_top;
  localparam int EXP_STAT_FRAME = 61;
  localparam int EXP_ACK_FRAME  = 80;
  localparam int N_VEC = 6;
  // {stall_mode[1:0], kind, loc[7:0], seed[15:0]}
  localparam logic [26:0] VEC [N_VEC] = '{
    {2'd0, 1'b0, 8'h05, 16'h1234},
    {2'd0, 1'b1, 8'hA7, 16'hBEEF},
    {2'd1, 1'b0, 8'hFF, 16'h0001},
    {2'd2, 1'b1, 8'h00, 16'h7777},
    {2'd3, 1'b0, 8'h3C, 16'hCAFE},
    {2'd3, 1'b1, 8'h81, 16'h0F0F}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         kind_i = 1'b0;
  logic [47:0]  dst_mac_i = '0, src_mac_i = '0;
  logic [7:0]   loc_i = '0;
  logic [9:0]   temp_i = '0;
  logic [95:0]  adc_i = '0;
  logic [447:0] dac_i = '0;
  logic         tx_ready_i = 1'b0;
  logic [7:0]   tx_data_o;
  logic         tx_valid_o, tx_last_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1;

  logic         s_kind;
  logic [47:0]  s_dst, s_src;
  logic [7:0]   s_loc;
  logic [9:0]   s_temp;
  logic [95:0]  s_adc;
  logic [447:0] s_dac;
  logic [7:0]   exp_q[$];
  logic [7:0]   got_q[$];

  always #10 clk_i = ~clk_i;

  stat_ack_frame_tx dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] step(input logic [31:0] x);
    return x * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic fill_inputs(input logic kind, input logic [7:0] loc, input logic [15:0] seed);
    rng = {seed, ~seed};
    kind_i = kind;
    loc_i = loc;
    rng = step(rng); dst_mac_i[47:16] = rng;
    rng = step(rng); dst_mac_i[15:0] = rng[31:16];
    rng = step(rng); src_mac_i[47:16] = rng;
    rng = step(rng); src_mac_i[15:0] = rng[31:16];
    rng = step(rng); temp_i = rng[25:16];
    for (int k = 0; k < 8; k++) begin
      rng = step(rng); adc_i[k*12 +: 12] = rng[27:16];
    end
    for (int k = 0; k < 32; k++) begin
      rng = step(rng); dac_i[k*14 +: 14] = rng[29:16];
    end
  endtask

  task automatic build_expected();
    logic [15:0] len;
    exp_q.delete();
    for (int b = 5; b >= 0; b--) exp_q.push_back(s_dst[b*8 +: 8]);
    for (int b = 5; b >= 0; b--) exp_q.push_back(s_src[b*8 +: 8]);
    len = s_kind ? 16'd66 : 16'd20;
    exp_q.push_back(len[15:8]);
    exp_q.push_back(len[7:0]);
    exp_q.push_back(s_loc);
    if (!s_kind) begin
      exp_q.push_back(8'h53);
      exp_q.push_back({6'b0, s_temp[9:8]});
      exp_q.push_back(s_temp[7:0]);
      for (int k = 0; k < 8; k++) begin
        exp_q.push_back({4'b0, s_adc[k*12+8 +: 4]});
        exp_q.push_back(s_adc[k*12 +: 8]);
      end
    end else begin
      exp_q.push_back(8'h44);
      for (int k = 0; k < 32; k++) begin
        exp_q.push_back({2'b0, s_dac[k*14+8 +: 6]});
        exp_q.push_back(s_dac[k*14 +: 8]);
      end
    end
    while (exp_q.size() < 14 + 47) exp_q.push_back(8'h00);
  endtask

  function automatic string req_of(input int i, input logic kind);
    int p = i - 14;
    if (i < 12) return "R2";
    if (i < 14) return "R3";
    if (kind) return "R6";
    if (p < 4) return "R4";
    if (p < 20) return "R5";
    return "R7";
  endfunction

  function automatic logic ready_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 2) == 0;
      2: return (cyc % 3) != 2;
      default: return (cyc % 8) >= 3;
    endcase
  endfunction

  // Entered and left at a negative clock edge
  task automatic run_frame(input int mode, input bit disturb, input bit start_at_last);
    bit   done = 0, disturbed = 0, prev_stall = 0, held_l = 0;
    logic [7:0] held_d = '0;
    int   cyc = 0;
    s_kind = kind_i; s_dst = dst_mac_i; s_src = src_mac_i; s_loc = loc_i;
    s_temp = temp_i; s_adc = adc_i; s_dac = dac_i;
    build_expected();
    got_q.delete();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done && cyc < 2000) begin
      tx_ready_i = ready_pat(mode, cyc);
      #1;
      if (prev_stall)
        chk(tx_valid_o && tx_data_o == held_d && tx_last_o == held_l, "R9", "held byte",
            int'(tx_data_o), int'(held_d));
      prev_stall = tx_valid_o && !tx_ready_i;
      held_d = tx_data_o;
      held_l = tx_last_o;
      if (tx_valid_o && tx_ready_i) begin
        got_q.push_back(tx_data_o);
        chk(tx_last_o == (got_q.size() == exp_q.size()), "R8", "last flag position",
            int'(tx_last_o), int'(got_q.size() == exp_q.size()));
        if (tx_last_o) done = 1;
      end
      if (disturb && !disturbed && got_q.size() == 20) begin
        disturbed = 1;
        start_i = 1'b1;
        fill_inputs(~s_kind, ~s_loc, 16'h5A5A);
      end else begin
        start_i = done && start_at_last;
      end
      cyc++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    tx_ready_i = 1'b0;
    #1;
    chk(!tx_valid_o, start_at_last ? "R10" : "R8", "valid after final byte", int'(tx_valid_o), 0);
    chk(got_q.size() == exp_q.size(), "R7", "frame byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req_of(i, s_kind), $sformatf("byte %0d", i),
          int'(got_q[i]), int'(exp_q[i]));
    @(negedge clk_i);
  endtask

  initial begin
    // R1: reset state
    #1;
    chk(!tx_valid_o && !tx_last_o && tx_data_o == 8'h00, "R1", "outputs in reset",
        int'({tx_valid_o, tx_last_o, tx_data_o}), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(!tx_valid_o && tx_data_o == 8'h00, "R1", "idle after reset",
        int'({tx_valid_o, tx_data_o}), 0);
    @(negedge clk_i);

    // Table walk: every frame also gets a mid-frame strobe with scrambled inputs (R10)
    for (int v = 0; v < N_VEC; v++) begin
      fill_inputs(VEC[v][24], VEC[v][23:16], VEC[v][15:0]);
      run_frame(int'(VEC[v][26:25]), 1'b1, 1'b0);
    end

    // R4 R5 R6: all-ones fields expose the zero padding of each high byte
    fill_inputs(1'b0, 8'hFF, 16'h0000);
    dst_mac_i = '1; src_mac_i = '1; temp_i = '1; adc_i = '1; dac_i = '1;
    run_frame(0, 1'b0, 1'b0);
    kind_i = 1'b1;
    run_frame(2, 1'b0, 1'b0);

    // R10: strobe in the final byte's handshake cycle is dropped
    fill_inputs(1'b0, 8'h42, 16'h2468);
    run_frame(0, 1'b0, 1'b1);
    #1;
    chk(!tx_valid_o, "R10", "still idle one cycle later", int'(tx_valid_o), 0);
    fill_inputs(1'b1, 8'h17, 16'h1357);
    run_frame(1, 1'b0, 1'b1);

    // R1: reset in the middle of a frame returns outputs to idle
    fill_inputs(1'b1, 8'h99, 16'h4321);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    tx_ready_i = 1'b1;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!tx_valid_o && !tx_last_o && tx_data_o == 8'h00, "R1", "outputs after mid-frame reset",
        int'({tx_valid_o, tx_last_o, tx_data_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tx_ready_i = 1'b0;
    @(negedge clk_i);
    fill_inputs(1'b0, 8'h21, 16'h9999);
    run_frame(3, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule